// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block is the protection and power-good controller for a synchronous buck regulator. It receives comparator results that are already digital: the output sitting under the undervoltage level, above the overvoltage trip level, below the overvoltage release level, and above the reference. It also receives a valley-overcurrent flag with a once-per-switching-cycle strobe, a peak way-overcurrent flag, a pair of die-temperature flags, the supply-good status, the enable input and the soft-start ramp-done flag. From these it decides whether the power stage may switch. It outputs permits for the high-side and low-side switches, a command to park the switch node in high impedance, a soft-discharge enable and power-good. It also reports the first fault it latched.

Each fault is latched and has its own output action. Undervoltage, either overcurrent and over-temperature shut the stage down with soft-discharge on. Overvoltage keeps the high-side switch off and runs a low-side-only crowbar that follows the reference comparator. A latched fault stays until enable is driven low or the supply-good status drops. A fault reacts one clock after the flag is sampled.

Top module: `reg_fault_supervisor`

## Requirements
- R1: While reset is asserted, or after any clock in which `porOk` is low, `hsPermit`, `lsPermit`, `softDischarge` and `powerGood` are 0, `triState` is 1 and `faultCode` is 0.
- R2: After a clock with `porOk` high and `enable` low, both permits and `powerGood` are 0, `triState` and `softDischarge` are 1, and `faultCode` is cleared to 0.
- R3: In normal running, both permits are 1 and `triState` and `softDischarge` are 0. `powerGood` is 1 exactly when `rampDone` is 1, `uvFlag` is 0 and `ovFallBelow` is 1.
- R4: `uvFlag` seen while `rampDone` is 1 latches a shutdown: both permits 0, `triState` 1, `softDischarge` 1, `powerGood` 0, fault code 4. `uvFlag` has no effect while `rampDone` is 0.
- R5: `ovRiseFlag` latches overvoltage mode with fault code 3. In this mode `hsPermit`, `softDischarge` and `powerGood` are 0, `lsPermit` equals `aboveRefFlag`, and `triState` is its inverse.
- R6: A `cycleStrobe` with `valleyOcFlag` high on 8 consecutive strobes latches a shutdown with fault code 2. A strobe with the flag low resets the run. Clocks without a strobe leave the run unchanged.
- R7: `wayOcFlag` latches a shutdown with fault code 1 on the next clock, from normal running and from overvoltage mode.
- R8: `otHighFlag` latches a shutdown with fault code 5. The thermal condition holds until `otLowFlag`. Re-enabling before that returns to shutdown, and after it re-enabling restarts.
- R9: A latched fault and its code persist after the causing flag clears, as long as `porOk` and `enable` stay high.
- R10: When faults arrive in the same clock, the recorded code follows the priority way-overcurrent (1), valley (2), overvoltage (3), undervoltage (4), thermal (5). A later fault never overwrites a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| porOk | input | 1 | Supplies above power-on-reset level |
| enable | input | 1 | Regulation enable |
| rampDone | input | 1 | Soft-start ramp has reached target |
| uvFlag | input | 1 | Output below undervoltage level |
| ovRiseFlag | input | 1 | Output above overvoltage trip level |
| ovFallBelow | input | 1 | Output below overvoltage release level |
| aboveRefFlag | input | 1 | Output above reference |
| valleyOcFlag | input | 1 | Valley current above limit this cycle |
| cycleStrobe | input | 1 | One pulse per switching cycle |
| wayOcFlag | input | 1 | Peak way-overcurrent |
| otHighFlag | input | 1 | Die temperature above shutdown level |
| otLowFlag | input | 1 | Die temperature below recovery level |
| hsPermit | output | 1 | High-side switch may be driven |
| lsPermit | output | 1 | Low-side switch may be driven |
| triState | output | 1 | Park switch node in high impedance |
| softDischarge | output | 1 | Soft-discharge switch on |
| powerGood | output | 1 | Output in regulation |
| faultCode | output | 3 | First latched fault, 0 when none |

## Verification
The bench aims at the valley-overcurrent run length. A counter that failed to reset on a flag-free strobe would trip after the second batch of seven strobes. A counter that advanced on clocks without a strobe would trip during the idle gap. It also puts an overvoltage and a valley trip in the same clock, so a wrong priority records code 3 instead of 2. Thermal hysteresis is exercised by re-enabling before and after the release flag: a design that dropped the thermal condition with the enable toggle would restart while still hot. Overvoltage mode is checked with the reference comparator toggling, which catches a low-side permit that does not track it or a soft-discharge left on.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_WAYOC  = 3'd1,
    FC_VALLEY = 3'd2,
    FC_OV     = 3'd3,
    FC_UV     = 3'd4,
    FC_THERM  = 3'd5
  } faultCode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_STANDBY,
    ST_RUN,
    ST_OVP,
    ST_SHUT
  } supState_e;

  typedef struct packed {
    logic       clearCode;
    logic       recordCode;
    faultCode_e codeValue;
    logic       countEnable;
  } ctlStrobes_t;

endpackage

// File: rtl/rfs_datapath.sv
module rfs_datapath
  import rfs_pkg::*;
#(
  parameter int OC_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        valleyOcFlag,
  input  logic        cycleStrobe,
  input  logic        otHighFlag,
  input  logic        otLowFlag,
  input  ctlStrobes_t strobes,
  output logic        valleyTrip,
  output logic        otActive,
  output logic [2:0]  faultCode
);

  localparam int CNT_W = $clog2(OC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(OC_CYCLES - 1);

  logic [CNT_W-1:0] valleyRun;
  faultCode_e       codeReg;

  // Trip on the strobe that completes the consecutive run.
  assign valleyTrip = strobes.countEnable && cycleStrobe && valleyOcFlag &&
                      (valleyRun == LAST_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valleyRun <= '0;
    end else if (!strobes.countEnable) begin
      valleyRun <= '0;
    end else if (cycleStrobe) begin
      if (!valleyOcFlag) begin
        valleyRun <= '0;
      end else if (valleyRun != LAST_COUNT) begin
        valleyRun <= valleyRun + 1'b1;
      end
    end
  end

  // Thermal hysteresis: set above shutdown level, released below recovery.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otActive <= 1'b0;
    end else if (otHighFlag) begin
      otActive <= 1'b1;
    end else if (otLowFlag) begin
      otActive <= 1'b0;
    end
  end

  // First-fault record, held until the clear strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= FC_NONE;
    end else if (strobes.clearCode) begin
      codeReg <= FC_NONE;
    end else if (strobes.recordCode && (codeReg == FC_NONE)) begin
      codeReg <= strobes.codeValue;
    end
  end

  assign faultCode = codeReg;

endmodule

// File: rtl/rfs_control.sv
module rfs_control
  import rfs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        porOk,
  input  logic        enable,
  input  logic        rampDone,
  input  logic        uvFlag,
  input  logic        ovRiseFlag,
  input  logic        ovFallBelow,
  input  logic        aboveRefFlag,
  input  logic        wayOcFlag,
  input  logic        otHighFlag,
  input  logic        valleyTrip,
  input  logic        otActive,
  output ctlStrobes_t strobes,
  output logic        hsPermit,
  output logic        lsPermit,
  output logic        triState,
  output logic        softDischarge,
  output logic        powerGood
);

  supState_e  state;
  supState_e  nextState;
  logic       recordFault;
  faultCode_e newCode;
  logic       thermTrip;

  assign thermTrip = otHighFlag || otActive;

  always_comb begin
    nextState   = state;
    recordFault = 1'b0;
    newCode     = FC_NONE;
    if (!porOk) begin
      nextState = ST_OFF;
    end else if (!enable) begin
      nextState = ST_STANDBY;
    end else begin
      unique case (state)
        ST_OFF, ST_STANDBY, ST_RUN: begin
          recordFault = 1'b1;
          if (wayOcFlag) begin
            nextState = ST_SHUT;
            newCode   = FC_WAYOC;
          end else if (valleyTrip) begin
            nextState = ST_SHUT;
            newCode   = FC_VALLEY;
          end else if (ovRiseFlag) begin
            nextState = ST_OVP;
            newCode   = FC_OV;
          end else if (uvFlag && rampDone) begin
            nextState = ST_SHUT;
            newCode   = FC_UV;
          end else if (thermTrip) begin
            nextState = ST_SHUT;
            newCode   = FC_THERM;
          end else begin
            nextState   = ST_RUN;
            recordFault = 1'b0;
          end
        end
        ST_OVP: begin
          if (wayOcFlag) begin
            nextState   = ST_SHUT;
            recordFault = 1'b1;
            newCode     = FC_WAYOC;
          end else if (thermTrip) begin
            nextState   = ST_SHUT;
            recordFault = 1'b1;
            newCode     = FC_THERM;
          end
        end
        ST_SHUT: nextState = ST_SHUT;
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    strobes.clearCode   = !porOk || !enable;
    strobes.recordCode  = recordFault;
    strobes.codeValue   = newCode;
    strobes.countEnable = (state == ST_RUN);
  end

  always_comb begin
    hsPermit      = 1'b0;
    lsPermit      = 1'b0;
    triState      = 1'b1;
    softDischarge = 1'b0;
    powerGood     = 1'b0;
    unique case (state)
      ST_OFF: ;
      ST_STANDBY, ST_SHUT: softDischarge = 1'b1;
      ST_RUN: begin
        hsPermit  = 1'b1;
        lsPermit  = 1'b1;
        triState  = 1'b0;
        powerGood = rampDone && !uvFlag && ovFallBelow;
      end
      ST_OVP: begin
        lsPermit = aboveRefFlag;
        triState = !aboveRefFlag;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import rfs_pkg::*;
#(
  parameter int OC_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porOk,
  input  logic       enable,
  input  logic       rampDone,
  input  logic       uvFlag,
  input  logic       ovRiseFlag,
  input  logic       ovFallBelow,
  input  logic       aboveRefFlag,
  input  logic       valleyOcFlag,
  input  logic       cycleStrobe,
  input  logic       wayOcFlag,
  input  logic       otHighFlag,
  input  logic       otLowFlag,
  output logic       hsPermit,
  output logic       lsPermit,
  output logic       triState,
  output logic       softDischarge,
  output logic       powerGood,
  output logic [2:0] faultCode
);

  ctlStrobes_t strobes;
  logic        valleyTrip;
  logic        otActive;

  rfs_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .porOk        (porOk),
    .enable       (enable),
    .rampDone     (rampDone),
    .uvFlag       (uvFlag),
    .ovRiseFlag   (ovRiseFlag),
    .ovFallBelow  (ovFallBelow),
    .aboveRefFlag (aboveRefFlag),
    .wayOcFlag    (wayOcFlag),
    .otHighFlag   (otHighFlag),
    .valleyTrip   (valleyTrip),
    .otActive     (otActive),
    .strobes      (strobes),
    .hsPermit     (hsPermit),
    .lsPermit     (lsPermit),
    .triState     (triState),
    .softDischarge(softDischarge),
    .powerGood    (powerGood)
  );

  rfs_datapath #(.OC_CYCLES(OC_CYCLES)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .valleyOcFlag(valleyOcFlag),
    .cycleStrobe (cycleStrobe),
    .otHighFlag  (otHighFlag),
    .otLowFlag   (otLowFlag),
    .strobes     (strobes),
    .valleyTrip  (valleyTrip),
    .otActive    (otActive),
    .faultCode   (faultCode)
  );

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       porOk,
  input logic       enable,
  input logic       rampDone,
  input logic       uvFlag,
  input logic       ovRiseFlag,
  input logic       wayOcFlag,
  input logic       hsPermit,
  input logic       lsPermit,
  input logic       triState,
  input logic       softDischarge,
  input logic       powerGood,
  input logic [2:0] faultCode
);

  assert_off_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    !porOk |=> (!hsPermit && !lsPermit && triState && !softDischarge && !powerGood));

  assert_standby_R2: assert property (@(posedge clk) disable iff (!rstN)
    (porOk && !enable) |=> (softDischarge && !hsPermit && !lsPermit && faultCode == 3'd0));

  assert_pg_context_R3: assert property (@(posedge clk) disable iff (!rstN)
    powerGood |-> (hsPermit && rampDone && !uvFlag && !softDischarge));

  assert_ov_hs_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ovRiseFlag && porOk && enable) |=> (!hsPermit && !powerGood));

  assert_way_oc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wayOcFlag && porOk && enable) |=> (!hsPermit && !lsPermit && softDischarge));

  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != 3'd0 && porOk && enable) |=> $stable(faultCode));

endmodule

bind reg_fault_supervisor rfs_checker i_checker (
  .clk          (clk),
  .rstN         (rstN),
  .porOk        (porOk),
  .enable       (enable),
  .rampDone     (rampDone),
  .uvFlag       (uvFlag),
  .ovRiseFlag   (ovRiseFlag),
  .wayOcFlag    (wayOcFlag),
  .hsPermit     (hsPermit),
  .lsPermit     (lsPermit),
  .triState     (triState),
  .softDischarge(softDischarge),
  .powerGood    (powerGood),
  .faultCode    (faultCode)
);

// File: tb/test_reg_fault_supervisor.sv
module test_reg_fault_supervisor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porOk = 1'b0, enable = 1'b0, rampDone = 1'b0, uvFlag = 1'b0;
  logic ovRiseFlag = 1'b0, ovFallBelow = 1'b0, aboveRefFlag = 1'b0;
  logic valleyOcFlag = 1'b0, cycleStrobe = 1'b0, wayOcFlag = 1'b0;
  logic otHighFlag = 1'b0, otLowFlag = 1'b0;
  logic hsPermit, lsPermit, triState, softDischarge, powerGood;
  logic [2:0] faultCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  reg_fault_supervisor i_reg_fault_supervisor (
    .clk(clk), .rstN(rstN), .porOk(porOk), .enable(enable), .rampDone(rampDone),
    .uvFlag(uvFlag), .ovRiseFlag(ovRiseFlag), .ovFallBelow(ovFallBelow),
    .aboveRefFlag(aboveRefFlag), .valleyOcFlag(valleyOcFlag), .cycleStrobe(cycleStrobe),
    .wayOcFlag(wayOcFlag), .otHighFlag(otHighFlag), .otLowFlag(otLowFlag),
    .hsPermit(hsPermit), .lsPermit(lsPermit), .triState(triState),
    .softDischarge(softDischarge), .powerGood(powerGood), .faultCode(faultCode)
  );

  // Inputs {por,en,ramp,uv,ovRise,ovFallBelow,aboveRef,valley,strobe,wayOc,otHigh,otLow}
  // Expected {hs,ls,tri,sd,pg,code[2:0]}
  localparam int NVEC = 23;
  localparam logic [19:0] VEC [NVEC] = '{
    {12'b100000000000, 8'b00110000},  // R2 standby
    {12'b110001000000, 8'b11000000},  // R3 run, ramp not done
    {12'b111001000000, 8'b11001000},  // R3 power good
    {12'b111000000000, 8'b11000000},  // R3 above release level
    {12'b110101000000, 8'b11000000},  // R4 uv ignored before ramp done
    {12'b111101000000, 8'b00110100},  // R4 uv shutdown
    {12'b111001000000, 8'b00110100},  // R9 latched
    {12'b101001000000, 8'b00110000},  // R2 clear
    {12'b111001000000, 8'b11001000},  // R3 restart
    {12'b111010100000, 8'b01000011},  // R5 ov, above ref
    {12'b111001000000, 8'b00100011},  // R5 below ref
    {12'b111001100000, 8'b01000011},  // R5 above ref again
    {12'b111001100100, 8'b00110011},  // R7 way oc from ov, code held
    {12'b000000000000, 8'b00100000},  // R1 supply lost
    {12'b111010000100, 8'b00110001},  // R10 way oc beats ov
    {12'b100000000000, 8'b00110000},  // R2 clear
    {12'b111001000010, 8'b00110101},  // R8 thermal
    {12'b111001000000, 8'b00110101},  // R8 held
    {12'b101001000000, 8'b00110000},  // R2 standby
    {12'b111001000000, 8'b00110101},  // R8 still hot
    {12'b111001000001, 8'b00110101},  // R8 released but latched
    {12'b101001000000, 8'b00110000},  // R2 toggle
    {12'b111001000000, 8'b11001000}   // R8 restart after cool
  };

  task automatic driveIn(input logic [11:0] v);
    {porOk, enable, rampDone, uvFlag, ovRiseFlag, ovFallBelow, aboveRefFlag,
     valleyOcFlag, cycleStrobe, wayOcFlag, otHighFlag, otLowFlag} = v;
  endtask

  task automatic checkOut(input logic [7:0] exp, input string req);
    logic [7:0] act;
    act = {hsPermit, lsPermit, triState, softDischarge, powerGood, faultCode};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic stepValley(input logic flag, input logic strobe);
    @(negedge clk);
    valleyOcFlag = flag;
    cycleStrobe = strobe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut(8'b00100000, "R1 reset");
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      driveIn(VEC[i][19:8]);
      @(negedge clk);
      checkOut(VEC[i][7:0], $sformatf("vector %0d", i));
    end

    // R6: valley run, reset by a flag-free strobe, held over strobe-free clocks
    for (int i = 0; i < 7; i++) stepValley(1'b1, 1'b1);
    stepValley(1'b0, 1'b1);
    @(negedge clk);
    checkOut(8'b11001000, "R6 seven strobes no trip");
    cycleStrobe = 1'b0;
    for (int i = 0; i < 7; i++) stepValley(1'b1, 1'b1);
    stepValley(1'b1, 1'b0);
    @(negedge clk);
    checkOut(8'b11001000, "R6 run reset by clean strobe");
    @(negedge clk);
    @(negedge clk);
    checkOut(8'b11001000, "R6 idle clocks no trip");
    // R10: eighth strobe together with overvoltage, valley wins
    cycleStrobe = 1'b1;
    ovRiseFlag = 1'b1;
    aboveRefFlag = 1'b1;
    ovFallBelow = 1'b0;
    @(negedge clk);
    checkOut(8'b00110010, "R6 R10 valley trip beats ov");
    cycleStrobe = 1'b0;
    valleyOcFlag = 1'b0;
    ovRiseFlag = 1'b0;
    @(negedge clk);
    checkOut(8'b00110010, "R9 valley latched");

    // R1: reset mid-run
    driveIn(12'b101001000000);
    @(negedge clk);
    driveIn(12'b111001000000);
    @(negedge clk);
    checkOut(8'b11001000, "R3 run before reset");
    rstN = 1'b0;
    @(negedge clk);
    checkOut(8'b00100000, "R1 async reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(8'b11001000, "R3 run after reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule